// File: doc/BRIEF.md
# Chip-Select Address Range Decoder

This block takes each bus address and picks the external device it belongs to. Six programmable address windows are held in registers. Each window has a compare word and a configuration word. The compare word holds a 64KB-aligned base and a don't-care mask over address bits 28:16. The configuration word holds a data width, a wait-state count and an enable. The decode path from address to outputs is purely combinational, so the bus sequencer can use the result in the same cycle the address appears.

Before comparing, the decoder clears the three uppermost address bits. Virtual addresses in the kernel segments therefore land on the physical window they alias. Disabled windows never match. When several enabled windows claim an address, the window with the lowest number is chosen. When nothing matches, a separate fallback configuration word supplies the width and wait count. Register writes arrive through a simple write port and take effect from the next clock edge.

At reset only window 0 is live. It covers a 2MB block at physical address 0x1FC00000, with 8-bit width and the maximum wait count, so the processor can fetch its first instructions.

Top module: `cs_range_decoder`

## Requirements
- R1: After reset, window 0 is enabled with base 0x1FC0 and mask 0x001F, width code 0 and wait count 31. Windows 1 to 5 are disabled. The fallback word holds width code 0, wait count 31 and enable 0.
- R2: In the compare word, bits 15:0 hold the base, which is compared against address bits 31:16. Bits 28:16 hold the mask. A set mask bit i makes address bit 16+i a don't-care, and every other compared bit must equal the base.
- R3: Address bits 31:29 are forced to zero before comparison, so 0xBE000010 and 0x3E000000 both hit a window based at 0x1E00 with mask 0.
- R4: A window whose enable bit (configuration bit 0) is clear never asserts its chip-select, whatever its compare word holds.
- R5: When several enabled windows match, only the lowest-numbered one is selected.
- R6: `cs_sel` has at most one bit set. `sel_idx` is the number of that bit. When no window matches, `cs_sel` is zero, `no_match` is 1 and `sel_idx` is 7.
- R7: On a hit, `sel_width` comes from bits 31:30 of the chosen window's configuration word (0 = 8-bit, 1 = 16-bit, 2 = 32-bit), `sel_waits` from bits 5:1, and `sel_enable` from bit 0.
- R8: On a miss, `sel_width`, `sel_waits` and `sel_enable` come from the fallback word written at byte offset 0x80, which uses the same field layout.
- R9: Configuration words sit at offsets 0x00 + 4*i and compare words at 0x40 + 4*i. A write changes the decode from the clock edge that captures it, and not before.
- R10: A write to any other offset, including a misaligned one, changes no window and no fallback field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_ofs | input | 8 | Byte offset of the register written |
| reg_wr_data | input | 32 | Write data |
| bus_addr | input | 32 | Address being decoded |
| cs_sel | output | 6 | One-hot chip-select of the chosen window |
| sel_idx | output | 3 | Number of the chosen window, 7 on a miss |
| no_match | output | 1 | High when no enabled window matches |
| sel_width | output | 2 | Data width code of the chosen configuration |
| sel_waits | output | 5 | Wait-state count of the chosen configuration |
| sel_enable | output | 1 | Enable bit of the chosen configuration |

## Verification
On every cycle, the assertions check the shape of the selection: the chip-select is one-hot or zero, a selected window is enabled and has no lower-numbered matching rival, and on a hit or a miss the presented fields follow the right configuration word. Further assertions check that clearing a window's enable takes its chip-select away on the next cycle, and that a write to an unmapped offset leaves the register state untouched. Only the bench scenarios can show whether the masked compare covers the right address span at its edges, whether the segment folding is correct, and what values the reset boot window holds.

// File: rtl/cs_dec_pkg.sv
package cs_dec_pkg;

    localparam int CS_RANGES  = 6;
    localparam int ADDR_W     = 32;
    localparam int REG_W      = 32;
    localparam int OFS_W      = 8;
    localparam int BLK_LSB    = 16;
    localparam int BASE_W     = ADDR_W - BLK_LSB;
    localparam int MASK_W     = 13;
    localparam int FOLD_BITS  = 3;
    localparam int WAIT_W     = 5;
    localparam int IDX_W      = $clog2(CS_RANGES + 1);
    localparam logic [IDX_W-1:0] NO_HIT_IDX = {IDX_W{1'b1}};

    localparam logic [OFS_W-1:0] CFG_OFS0 = 8'h00;
    localparam logic [OFS_W-1:0] CMP_OFS0 = 8'h40;
    localparam logic [OFS_W-1:0] DFLT_OFS = 8'h80;

    typedef enum logic [1:0] {
        BW_8   = 2'd0,
        BW_16  = 2'd1,
        BW_32  = 2'd2,
        BW_RSV = 2'd3
    } bus_width_e;

    typedef struct packed {
        bus_width_e        width;
        logic [WAIT_W-1:0] waits;
        logic              enable;
    } range_cfg_t;

    typedef struct packed {
        logic [MASK_W-1:0] mask;
        logic [BASE_W-1:0] base;
    } range_cmp_t;

    localparam range_cfg_t CFG_OFF  = '{width: BW_8, waits: {WAIT_W{1'b0}}, enable: 1'b0};
    localparam range_cfg_t BOOT_CFG = '{width: BW_8, waits: {WAIT_W{1'b1}}, enable: 1'b1};
    localparam range_cfg_t DFLT_RST = '{width: BW_8, waits: {WAIT_W{1'b1}}, enable: 1'b0};
    localparam range_cmp_t CMP_OFF  = '{mask: {MASK_W{1'b0}}, base: {BASE_W{1'b0}}};
    localparam range_cmp_t BOOT_CMP = '{mask: 13'h001F, base: 16'h1FC0};

    function automatic logic [OFS_W-1:0] cfg_ofs(input int idx);
        return CFG_OFS0 + OFS_W'(4 * idx);
    endfunction

    function automatic logic [OFS_W-1:0] cmp_ofs(input int idx);
        return CMP_OFS0 + OFS_W'(4 * idx);
    endfunction

    function automatic range_cfg_t unpack_cfg(input logic [REG_W-1:0] w);
        range_cfg_t c;
        c.width  = bus_width_e'(w[31:30]);
        c.waits  = w[WAIT_W:1];
        c.enable = w[0];
        return c;
    endfunction

    function automatic range_cmp_t unpack_cmp(input logic [REG_W-1:0] w);
        range_cmp_t c;
        c.mask = w[BLK_LSB +: MASK_W];
        c.base = w[BASE_W-1:0];
        return c;
    endfunction

    function automatic logic [ADDR_W-1:0] fold_phys(input logic [ADDR_W-1:0] a);
        return {{FOLD_BITS{1'b0}}, a[ADDR_W-FOLD_BITS-1:0]};
    endfunction

    function automatic logic block_hit(input logic [BASE_W-1:0] blk, input range_cmp_t c);
        logic [BASE_W-1:0] care;
        care = ~{{(BASE_W-MASK_W){1'b0}}, c.mask};
        return ((blk ^ c.base) & care) == '0;
    endfunction

endpackage

// File: rtl/cs_cfg_regs.sv
module cs_cfg_regs
    import cs_dec_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [OFS_W-1:0]    wr_ofs,
    input  logic [REG_W-1:0]    wr_data,
    output range_cfg_t          cfg_o [CS_RANGES],
    output range_cmp_t          cmp_o [CS_RANGES],
    output range_cfg_t          dflt_o
);

    localparam int CFG_BITS = $bits(range_cfg_t);
    localparam int CMP_BITS = $bits(range_cmp_t);
    localparam int ENTRY_W  = CFG_BITS + CMP_BITS;
    localparam int STATE_W  = CS_RANGES * ENTRY_W + CFG_BITS;

    logic [CS_RANGES-1:0] cfg_we;
    logic [CS_RANGES-1:0] cmp_we;
    logic                 dflt_we;
    logic                 mapped;
    range_cfg_t           new_cfg;
    range_cmp_t           new_cmp;
    range_cfg_t           dflt_q;
    logic [STATE_W-1:0]   state_flat;
    logic                 unused_data_bits;

    assign new_cfg = unpack_cfg(wr_data);
    assign new_cmp = unpack_cmp(wr_data);
    assign dflt_we = wr_en && (wr_ofs == DFLT_OFS);
    assign mapped  = (|cfg_we) || (|cmp_we) || dflt_we;
    assign unused_data_bits = ^{wr_data[29:WAIT_W+1], wr_data[31:BLK_LSB+MASK_W]};

    for (genvar i = 0; i < CS_RANGES; i++) begin : g_win
        localparam range_cfg_t RST_CFG = (i == 0) ? BOOT_CFG : CFG_OFF;
        localparam range_cmp_t RST_CMP = (i == 0) ? BOOT_CMP : CMP_OFF;

        assign cfg_we[i] = wr_en && (wr_ofs == cfg_ofs(i));
        assign cmp_we[i] = wr_en && (wr_ofs == cmp_ofs(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_o[i] <= RST_CFG;
                cmp_o[i] <= RST_CMP;
            end else begin
                if (cfg_we[i]) cfg_o[i] <= new_cfg;
                if (cmp_we[i]) cmp_o[i] <= new_cmp;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          dflt_q <= DFLT_RST;
        else if (dflt_we) dflt_q <= new_cfg;
    end

    assign dflt_o = dflt_q;

    always_comb begin
        state_flat = '0;
        for (int i = 0; i < CS_RANGES; i++)
            state_flat[i*ENTRY_W +: ENTRY_W] = {cfg_o[i], cmp_o[i]};
        state_flat[STATE_W-1 -: CFG_BITS] = dflt_q;
    end

    // R10: a write that decodes to no register leaves all state alone
    assert_unmapped_write_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !mapped) |=> $stable(state_flat));

    // R9: at most one register is addressed by any write
    assert_single_target_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cfg_we, cmp_we, dflt_we}));

endmodule

// File: rtl/cs_window_match.sv
module cs_window_match
    import cs_dec_pkg::*;
(
    input  logic [ADDR_W-1:0]    addr,
    input  range_cfg_t           cfg   [CS_RANGES],
    input  range_cmp_t           cmp   [CS_RANGES],
    output logic [CS_RANGES-1:0] hit
);

    logic [ADDR_W-1:0] phys;
    logic              unused_low_addr;

    assign phys            = fold_phys(addr);
    assign unused_low_addr = ^phys[BLK_LSB-1:0];

    for (genvar i = 0; i < CS_RANGES; i++) begin : g_cmp
        assign hit[i] = cfg[i].enable && block_hit(phys[ADDR_W-1:BLK_LSB], cmp[i]);
    end

endmodule

// File: rtl/cs_prio_pick.sv
module cs_prio_pick
    import cs_dec_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [CS_RANGES-1:0] hit,
    input  range_cfg_t           cfg   [CS_RANGES],
    input  range_cfg_t           dflt,
    output logic [CS_RANGES-1:0] cs,
    output logic [IDX_W-1:0]     idx,
    output logic                 miss,
    output range_cfg_t           pick
);

    always_comb begin
        cs   = '0;
        idx  = NO_HIT_IDX;
        miss = 1'b1;
        pick = dflt;
        for (int i = CS_RANGES - 1; i >= 0; i--) begin
            if (hit[i]) begin
                cs    = '0;
                cs[i] = 1'b1;
                idx   = IDX_W'(i);
                miss  = 1'b0;
                pick  = cfg[i];
            end
        end
    end

    // R6: one-hot select, miss flag consistent with it
    assert_onehot_select_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cs) && (miss == (cs == '0)));

    // R8: a miss presents the fallback word
    assert_fallback_on_miss_R8: assert property (@(posedge clk) disable iff (rst)
        miss |-> (pick == dflt) && (idx == NO_HIT_IDX));

    for (genvar i = 0; i < CS_RANGES; i++) begin : g_chk
        localparam logic [CS_RANGES-1:0] LOWER = CS_RANGES'((1 << i) - 1);

        // R5: a selected window has no lower-numbered matching rival
        assert_lowest_wins_R5: assert property (@(posedge clk) disable iff (rst)
            cs[i] |-> hit[i] && ((hit & LOWER) == '0));

        // R7: a hit presents that window's configuration
        assert_hit_fields_R7: assert property (@(posedge clk) disable iff (rst)
            cs[i] |-> (pick == cfg[i]) && (idx == IDX_W'(i)));
    end

endmodule

// File: rtl/cs_range_decoder.sv
module cs_range_decoder
    import cs_dec_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_wr_en,
    input  logic [OFS_W-1:0]     reg_wr_ofs,
    input  logic [REG_W-1:0]     reg_wr_data,
    input  logic [ADDR_W-1:0]    bus_addr,
    output logic [CS_RANGES-1:0] cs_sel,
    output logic [IDX_W-1:0]     sel_idx,
    output logic                 no_match,
    output logic [1:0]           sel_width,
    output logic [WAIT_W-1:0]    sel_waits,
    output logic                 sel_enable
);

    range_cfg_t           cfg  [CS_RANGES];
    range_cmp_t           cmp  [CS_RANGES];
    range_cfg_t           dflt;
    range_cfg_t           pick;
    logic [CS_RANGES-1:0] hit;

    cs_cfg_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr_en),
        .wr_ofs  (reg_wr_ofs),
        .wr_data (reg_wr_data),
        .cfg_o   (cfg),
        .cmp_o   (cmp),
        .dflt_o  (dflt)
    );

    cs_window_match u_match (
        .addr (bus_addr),
        .cfg  (cfg),
        .cmp  (cmp),
        .hit  (hit)
    );

    cs_prio_pick u_pick (
        .clk  (clk),
        .rst  (rst),
        .hit  (hit),
        .cfg  (cfg),
        .dflt (dflt),
        .cs   (cs_sel),
        .idx  (sel_idx),
        .miss (no_match),
        .pick (pick)
    );

    assign sel_width  = pick.width;
    assign sel_waits  = pick.waits;
    assign sel_enable = pick.enable;

    for (genvar i = 0; i < CS_RANGES; i++) begin : g_guard
        // R4: a disabled window is never selected
        assert_disabled_quiet_R4: assert property (@(posedge clk) disable iff (rst)
            cs_sel[i] |-> cfg[i].enable);

        // R9: clearing the enable removes the select from the next cycle
        assert_disable_write_R9: assert property (@(posedge clk) disable iff (rst)
            (reg_wr_en && (reg_wr_ofs == cfg_ofs(i)) && !reg_wr_data[0]) |=> !cs_sel[i]);
    end

endmodule

// File: tb/cs_range_decoder_tb.sv
module cs_range_decoder_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_ofs = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] addr = '0;
    logic [5:0]  cs_sel;
    logic [2:0]  sel_idx;
    logic        no_match;
    logic [1:0]  sel_width;
    logic [4:0]  sel_waits;
    logic        sel_enable;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cs_range_decoder u_dut (
        .clk         (clk),
        .rst         (rst),
        .reg_wr_en   (wr_en),
        .reg_wr_ofs  (wr_ofs),
        .reg_wr_data (wr_data),
        .bus_addr    (addr),
        .cs_sel      (cs_sel),
        .sel_idx     (sel_idx),
        .no_match    (no_match),
        .sel_width   (sel_width),
        .sel_waits   (sel_waits),
        .sel_enable  (sel_enable)
    );

    // expected result: {cs, idx, no_match, width, waits, enable}
    function automatic logic [17:0] hexp(input int w, input int bw, input int wt, input int en);
        return {6'(1 << w), 3'(w), 1'b0, 2'(bw), 5'(wt), 1'(en)};
    endfunction

    function automatic logic [17:0] mexp(input int bw, input int wt, input int en);
        return {6'b0, 3'd7, 1'b1, 2'(bw), 5'(wt), 1'(en)};
    endfunction

    localparam logic [31:0] T_ADDR [NVEC] = '{
        32'h0000_0000, 32'h00FF_FFFC, 32'h0100_0000, 32'h0101_FFFF,
        32'h0102_0000, 32'hBE00_0010, 32'h1E01_0000, 32'h0E00_0000,
        32'hA000_0100, 32'h80FF_FFFF, 32'hBFC0_0000, 32'h3E00_0000
    };

    localparam logic [17:0] T_EXP [NVEC] = '{
        hexp(1, 2, 3, 1),   // R5 overlap of windows 1 and 4
        hexp(1, 2, 3, 1),   // R2 top of 16MB span
        hexp(2, 1, 5, 1),   // R2 bottom of 128KB span
        hexp(2, 1, 5, 1),   // R2 top of 128KB span
        mexp(2, 9, 1),      // R8 just past 128KB span
        hexp(3, 2, 0, 1),   // R3 uncached alias
        mexp(2, 9, 1),      // R2 mask 0 is one 64KB block
        mexp(2, 9, 1),      // R4 disabled window 5
        hexp(1, 2, 3, 1),   // R3 uncached alias of window 1
        hexp(1, 2, 3, 1),   // R3 cached alias of window 1
        hexp(0, 0, 31, 1),  // R7 boot window fields
        hexp(3, 2, 0, 1)    // R3 bit 29 also cleared
    };

    function automatic string t_req(input int k);
        case (k)
            0:             return "R5";
            1, 2, 3, 6:    return "R2";
            4:             return "R8";
            7:             return "R4";
            10:            return "R7";
            default:       return "R3";
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] a, input logic [17:0] exp);
        logic [17:0] got;
        addr = a;
        #1;
        got = {cs_sel, sel_idx, no_match, sel_width, sel_waits, sel_enable};
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s addr=%h actual=%h expected=%h", req, a, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] o, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_ofs = o; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1", 32'hBFC0_0000, hexp(0, 0, 31, 1));
        chk("R1", 32'h1FDF_FFFF, hexp(0, 0, 31, 1));
        chk("R1", 32'h1FE0_0000, mexp(0, 31, 0));
        chk("R1", 32'h0000_0000, mexp(0, 31, 0));  // windows 1-5 off

        // program windows and fallback
        wr(8'h04, 32'h8000_0007); wr(8'h44, 32'h00FF_0000);
        wr(8'h08, 32'h4000_000B); wr(8'h48, 32'h0001_0100);
        wr(8'h0C, 32'h8000_0001); wr(8'h4C, 32'h0000_1E00);
        wr(8'h10, 32'h4000_000F); wr(8'h50, 32'h0001_0000);
        wr(8'h14, 32'h0000_0004); wr(8'h54, 32'h0000_0E00);
        wr(8'h80, 32'h8000_0013);
        @(negedge clk);

        for (int k = 0; k < NVEC; k++)
            chk(t_req(k), T_ADDR[k], T_EXP[k]);

        // R9: compare write of window 0 takes effect only at the capturing edge
        @(negedge clk);
        wr_en = 1'b1; wr_ofs = 8'h40; wr_data = 32'h0000_0000;
        #(CLK_PERIOD/2 - 2);
        chk("R9", 32'h0000_0000, hexp(1, 2, 3, 1));
        @(negedge clk);
        wr_en = 1'b0;
        chk("R9", 32'h0000_0000, hexp(0, 0, 31, 1));
        chk("R5", 32'h0000_FFFF, hexp(0, 0, 31, 1));

        // R9: clearing window 0 enable hands the address back to window 1
        wr(8'h00, 32'h0000_003E);
        chk("R9", 32'h0000_0000, hexp(1, 2, 3, 1));

        // R10: unmapped and misaligned writes change nothing
        wr(8'h18, 32'hFFFF_FFFF);
        wr(8'h58, 32'hFFFF_FFFF);
        wr(8'h84, 32'hFFFF_FFFF);
        wr(8'h41, 32'hFFFF_FFFF);
        wr(8'h01, 32'hFFFF_FFFF);
        chk("R10", 32'h0102_0000, mexp(2, 9, 1));
        chk("R10", 32'h0100_0000, hexp(2, 1, 5, 1));
        chk("R10", 32'h0E00_0000, mexp(2, 9, 1));
        chk("R10", 32'h1E00_0000, hexp(3, 2, 0, 1));
        chk("R10", 32'h0000_0000, hexp(1, 2, 3, 1));

        // R6/R8: reserved-width fallback passes straight through on a miss
        wr(8'h80, 32'hC000_0000);
        chk("R8", 32'h1234_0000, mexp(3, 0, 0));
        chk("R6", 32'hBE00_0000, hexp(3, 2, 0, 1));

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule